// File: doc/BRIEF.md
# Multi-Format Audio Sample Converter

This block sits between a serial audio port and a digital audio datapath. On the receive side it turns the 16-bit sample fields taken from the port into 16-bit two's-complement linear samples. On the transmit side it turns linear samples from the datapath back into 16-bit port fields. Each direction handles a left channel and a right channel.

A 2-bit format select picks one of four encodings for all traffic. The options are 16-bit linear, 8-bit offset-binary linear, 8-bit mu-law and 8-bit A-law. An 8-bit code always occupies the upper byte of its 16-bit field, so full scale has the same meaning in every format. The companded formats follow the usual telephony segment codes. A mono flag makes the left sample serve both channels on receive and blanks the right field on transmit.

Each direction has its own load strobe. A strobe registers the converted values, and they appear on the outputs one clock later. The registers keep their contents until the next strobe.

Top module: `sample_fmt_conv`

## Requirements
- R1: While `rst_n` is low, all four outputs read zero. They stay zero until a load strobe is accepted, and strobes are accepted starting with the third rising edge after `rst_n` goes high.
- R2: Format select 2'b00 is 16-bit linear. The clock edge that samples `rx_load` high puts each received field unchanged on its linear output. The clock edge that samples `tx_load` high puts each linear input unchanged on its transmit field.
- R3: Format select 2'b01 is 8-bit offset binary. On receive, the linear sample is {~f[15], f[14:8], 8'h00} for a field f, so the field's low byte is ignored.
- R4: In format 2'b01 the transmit field is {~s[15], s[14:8], 8'h00} for a linear sample s.
- R5: Format select 2'b10 is mu-law. The received code c = f[15:8] is inverted to u, where u[7] is the sign (1 means negative), u[6:4] is the segment e and u[3:0] is the mantissa m. The output is ±((8m+132)·2^e − 132), which is the 14-bit expansion left-aligned by two bits.
- R6: On mu-law transmit, the sample is first truncated to 14 bits by an arithmetic shift right of 2. The magnitude is clipped to 8159, and 33 is added. The segment is the smallest e with value ≤ 64·2^e − 1, and the mantissa is bits e+4 down to e+1 of that value. The code is {0,e,m} XOR 8'hFF for non-negative samples and XOR 8'h7F for negative ones. It is placed in field bits [15:8].
- R7: Format select 2'b11 is A-law. The received code XOR 8'h55 gives a. Here a[7] = 1 means positive, a[6:4] is the segment e and a[3:0] is the mantissa m. For e = 0 the magnitude is 16m+8. For e > 0 it is (16m+264)·2^(e−1). This is the 13-bit expansion left-aligned by three bits.
- R8: On A-law transmit, the sample is truncated to 13 bits by an arithmetic shift right of 3. A negative value p is replaced by −p−1. The segment is the smallest e with p ≤ 32·2^e − 1. The mantissa is p[4:1] when e < 2 and p[e+3:e] otherwise. The code is {0,e,m} XOR 8'hD5 for non-negative samples and XOR 8'h55 for negative ones.
- R9: In every 8-bit format (2'b01, 2'b10, 2'b11), both transmit fields carry 8'h00 in bits [7:0]. Bits [7:0] of a received field have no effect on the result.
- R10: With `mono` high, the received right field is ignored. After a receive load, `lin_right_out` equals `lin_left_out`, both converted from the left field.
- R11: With `mono` high, a transmit load drives `tx_right_field` to all zeros.
- R12: While a load strobe is low, the outputs of that direction hold their last values whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fmt_sel | input | 2 | Sample format: 00 linear16, 01 offset-binary 8, 10 mu-law, 11 A-law |
| mono | input | 1 | Mono mode: left feeds both channels on receive, right field zeroed on transmit |
| rx_load | input | 1 | Register the converted receive fields |
| rx_left_field | input | 16 | Received left 16-bit field |
| rx_right_field | input | 16 | Received right 16-bit field |
| lin_left_out | output | 16 | Left linear sample toward the datapath |
| lin_right_out | output | 16 | Right linear sample toward the datapath |
| tx_load | input | 1 | Register the converted transmit fields |
| lin_left_in | input | 16 | Left linear sample from the datapath |
| lin_right_in | input | 16 | Right linear sample from the datapath |
| tx_left_field | output | 16 | Left 16-bit field toward the port |
| tx_right_field | output | 16 | Right 16-bit field toward the port |

## Verification
The bench instantiates the block with its default two-stage reset release and the fixed 16-bit field and 8-bit code sizes. With those values, all 256 mu-law and A-law codes can be swept exhaustively on receive, on both channels and in both mono settings. On the transmit side, a stepped sweep over the whole signed range hits every segment boundary, the mu-law clip point and both ends of full scale.

// File: rtl/afc_pkg.sv
package afc_pkg;

  localparam int FIELD_W = 16;
  localparam int CODE_W  = 8;
  localparam int NUM_CH  = 2;
  localparam int SEG_W   = 3;
  localparam int MAN_W   = 4;
  // truncated linear widths before companding
  localparam int MU_W    = 14;
  localparam int AL_W    = 13;
  localparam int MU_SH   = FIELD_W - MU_W;
  localparam int AL_SH   = FIELD_W - AL_W;

  localparam logic [FIELD_W-1:0] MU_EXP_BIAS = FIELD_W'(132);
  localparam logic [MU_W:0]      MU_CLIP     = (MU_W+1)'(8159);
  localparam logic [MU_W:0]      MU_ENC_BIAS = (MU_W+1)'(33);
  localparam logic [CODE_W-1:0]  AL_FLIP     = 8'h55;
  localparam logic [CODE_W-1:0]  AL_FLIP_POS = 8'hD5;
  localparam logic [CODE_W-1:0]  MU_FLIP_POS = 8'hFF;
  localparam logic [CODE_W-1:0]  MU_FLIP_NEG = 8'h7F;
  localparam logic [FIELD_W-1:0] AL_SEG0_ADD = FIELD_W'(8);
  localparam logic [FIELD_W-1:0] AL_SEGN_ADD = FIELD_W'(264);

  typedef enum logic [1:0] {
    FMT_LIN16 = 2'b00,
    FMT_OFS8  = 2'b01,
    FMT_MULAW = 2'b10,
    FMT_ALAW  = 2'b11
  } fmt_e;

  typedef logic [FIELD_W-1:0] field_t;

endpackage

// File: rtl/afc_expand.sv
module afc_expand
  import afc_pkg::*;
(
  input  fmt_e   fmt_i,
  input  field_t field_i,
  output field_t pcm_o
);

  logic [CODE_W-1:0] code;
  logic [CODE_W-1:0] mu_inv;
  logic [CODE_W-1:0] al_flip;
  logic [SEG_W-1:0]  mu_seg;
  logic [SEG_W-1:0]  al_seg;
  logic [MAN_W-1:0]  mu_man;
  logic [MAN_W-1:0]  al_man;
  field_t            mu_base;
  field_t            mu_mag;
  field_t            mu_pcm;
  field_t            al_base;
  field_t            al_mag;
  field_t            al_pcm;

  // mu-law: inverted code, biased mantissa shifted by segment
  always_comb begin
    code    = field_i[FIELD_W-1 -: CODE_W];
    mu_inv  = ~code;
    mu_seg  = mu_inv[CODE_W-2 -: SEG_W];
    mu_man  = mu_inv[MAN_W-1:0];
    mu_base = FIELD_W'({mu_man, 3'b000}) + MU_EXP_BIAS;
    mu_mag  = (mu_base << mu_seg) - MU_EXP_BIAS;
    mu_pcm  = mu_inv[CODE_W-1] ? (field_t'(0) - mu_mag) : mu_mag;
  end

  // A-law: even-bit flip, segment zero is linear
  always_comb begin
    al_flip = code ^ AL_FLIP;
    al_seg  = al_flip[CODE_W-2 -: SEG_W];
    al_man  = al_flip[MAN_W-1:0];
    al_base = FIELD_W'({al_man, 4'b0000}) +
              ((al_seg == '0) ? AL_SEG0_ADD : AL_SEGN_ADD);
    if (al_seg <= SEG_W'(1)) begin
      al_mag = al_base;
    end else begin
      al_mag = al_base << (al_seg - SEG_W'(1));
    end
    al_pcm = al_flip[CODE_W-1] ? al_mag : (field_t'(0) - al_mag);
  end

  always_comb begin
    unique case (fmt_i)
      FMT_LIN16: pcm_o = field_i;
      FMT_OFS8:  pcm_o = {~field_i[FIELD_W-1], field_i[FIELD_W-2 -: CODE_W-1],
                          {(FIELD_W-CODE_W){1'b0}}};
      FMT_MULAW: pcm_o = mu_pcm;
      FMT_ALAW:  pcm_o = al_pcm;
      default:   pcm_o = field_i;
    endcase
  end

endmodule

// File: rtl/afc_compress.sv
module afc_compress
  import afc_pkg::*;
(
  input  fmt_e   fmt_i,
  input  field_t pcm_i,
  output field_t field_o
);

  logic              neg;
  logic [MU_W:0]     mu_ext;
  logic [MU_W:0]     mu_mag;
  logic [MU_W:0]     mu_clip;
  logic [MU_W:0]     mu_biased;
  logic              mu_over;
  logic [SEG_W-1:0]  mu_seg;
  logic [MAN_W-1:0]  mu_man;
  logic [CODE_W-1:0] mu_code;
  logic [AL_W-2:0]   al_p;
  logic [SEG_W-1:0]  al_seg;
  logic [MAN_W-1:0]  al_man;
  logic [CODE_W-1:0] al_code;

  assign neg = pcm_i[FIELD_W-1];

  // mu-law: truncate to 14 bits, magnitude, clip, bias, segment search
  always_comb begin
    mu_ext    = {neg, pcm_i[FIELD_W-1:MU_SH]};
    mu_mag    = neg ? ((MU_W+1)'(0) - mu_ext) : mu_ext;
    mu_clip   = (mu_mag > MU_CLIP) ? MU_CLIP : mu_mag;
    mu_biased = mu_clip + MU_ENC_BIAS;
    mu_over   = mu_biased[MU_W-1];
    mu_seg    = '0;
    for (int k = 0; k < 7; k++) begin
      if (mu_biased[6+k]) mu_seg = SEG_W'(k + 1);
    end
    mu_man  = MAN_W'(mu_biased >> ({1'b0, mu_seg} + 4'd1));
    mu_code = (mu_over ? MU_FLIP_NEG : {1'b0, mu_seg, mu_man}) ^
              (neg ? MU_FLIP_NEG : MU_FLIP_POS);
  end

  // A-law: truncate to 13 bits, one's complement for negatives
  always_comb begin
    al_p   = neg ? ~pcm_i[FIELD_W-2:AL_SH] : pcm_i[FIELD_W-2:AL_SH];
    al_seg = '0;
    for (int k = 0; k < 7; k++) begin
      if (al_p[5+k]) al_seg = SEG_W'(k + 1);
    end
    if (al_seg < SEG_W'(2)) begin
      al_man = al_p[4:1];
    end else begin
      al_man = MAN_W'(al_p >> al_seg);
    end
    al_code = {1'b0, al_seg, al_man} ^ (neg ? AL_FLIP : AL_FLIP_POS);
  end

  always_comb begin
    unique case (fmt_i)
      FMT_LIN16: field_o = pcm_i;
      FMT_OFS8:  field_o = {~pcm_i[FIELD_W-1], pcm_i[FIELD_W-2 -: CODE_W-1],
                            {(FIELD_W-CODE_W){1'b0}}};
      FMT_MULAW: field_o = {mu_code, {(FIELD_W-CODE_W){1'b0}}};
      FMT_ALAW:  field_o = {al_code, {(FIELD_W-CODE_W){1'b0}}};
      default:   field_o = pcm_i;
    endcase
  end

endmodule

// File: rtl/afc_rst_sync.sv
module afc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[STAGES-1];

endmodule

// File: rtl/sample_fmt_conv.sv
module sample_fmt_conv
  import afc_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         fmt_sel,
  input  logic               mono,
  input  logic               rx_load,
  input  logic [FIELD_W-1:0] rx_left_field,
  input  logic [FIELD_W-1:0] rx_right_field,
  output logic [FIELD_W-1:0] lin_left_out,
  output logic [FIELD_W-1:0] lin_right_out,
  input  logic               tx_load,
  input  logic [FIELD_W-1:0] lin_left_in,
  input  logic [FIELD_W-1:0] lin_right_in,
  output logic [FIELD_W-1:0] tx_left_field,
  output logic [FIELD_W-1:0] tx_right_field
);

  logic   rst_sync_n;
  fmt_e   fmt;
  field_t rx_fld  [NUM_CH];
  field_t tx_pcm  [NUM_CH];
  field_t exp_pcm [NUM_CH];
  field_t cmp_fld [NUM_CH];
  field_t sel_pcm [NUM_CH];
  field_t sel_fld [NUM_CH];
  field_t lin_q   [NUM_CH];
  field_t lin_d   [NUM_CH];
  field_t txf_q   [NUM_CH];
  field_t txf_d   [NUM_CH];

  afc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign fmt       = fmt_e'(fmt_sel);
  assign rx_fld[0] = rx_left_field;
  assign rx_fld[1] = rx_right_field;
  assign tx_pcm[0] = lin_left_in;
  assign tx_pcm[1] = lin_right_in;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    afc_expand u_exp (
      .fmt_i   (fmt),
      .field_i (rx_fld[ch]),
      .pcm_o   (exp_pcm[ch])
    );
    afc_compress u_cmp (
      .fmt_i   (fmt),
      .pcm_i   (tx_pcm[ch]),
      .field_o (cmp_fld[ch])
    );
    if (ch == 0) begin : g_lead
      assign sel_pcm[ch] = exp_pcm[ch];
      assign sel_fld[ch] = cmp_fld[ch];
    end else begin : g_follow
      // mono: left sample feeds every channel, other fields blanked
      assign sel_pcm[ch] = mono ? exp_pcm[0] : exp_pcm[ch];
      assign sel_fld[ch] = mono ? field_t'(0) : cmp_fld[ch];
    end

    always_comb begin
      lin_d[ch] = rx_load ? sel_pcm[ch] : lin_q[ch];
      txf_d[ch] = tx_load ? sel_fld[ch] : txf_q[ch];
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        lin_q[ch] <= '0;
        txf_q[ch] <= '0;
      end else begin
        lin_q[ch] <= lin_d[ch];
        txf_q[ch] <= txf_d[ch];
      end
    end
  end

  assign lin_left_out   = lin_q[0];
  assign lin_right_out  = lin_q[1];
  assign tx_left_field  = txf_q[0];
  assign tx_right_field = txf_q[1];

endmodule

// File: rtl/afc_conv_chk.sv
module afc_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rst_sync_n,
  input logic [1:0]  fmt_sel,
  input logic        mono,
  input logic        rx_load,
  input logic        tx_load,
  input logic [15:0] rx_left_field,
  input logic [15:0] lin_left_out,
  input logic [15:0] lin_right_out,
  input logic [15:0] tx_left_field,
  input logic [15:0] tx_right_field
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_zero_chk: assert (lin_left_out == '0 && lin_right_out == '0 &&
                              tx_left_field == '0 && tx_right_field == '0);
    end
  end

  // R2
  lin_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_load && fmt_sel == 2'b00 |=> lin_left_out == $past(rx_left_field));

  // R3
  ofs_low_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_load && fmt_sel == 2'b01 |=> lin_left_out[7:0] == 8'h00);

  // R5
  mu_align_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_load && fmt_sel == 2'b10 |=> lin_left_out[1:0] == 2'b00);

  // R7
  al_align_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_load && fmt_sel == 2'b11 |=> lin_left_out[2:0] == 3'b000);

  // R9
  tx_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_load && fmt_sel != 2'b00 |=>
      tx_left_field[7:0] == 8'h00 && tx_right_field[7:0] == 8'h00);

  // R10
  mono_rx_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_load && mono |=> lin_right_out == lin_left_out);

  // R11
  mono_tx_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_load && mono |=> tx_right_field == 16'h0000);

  // R12
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rx_load |=> $stable(lin_left_out) && $stable(lin_right_out));

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tx_load |=> $stable(tx_left_field) && $stable(tx_right_field));

endmodule

bind sample_fmt_conv afc_conv_chk u_conv_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rst_sync_n     (rst_sync_n),
  .fmt_sel        (fmt_sel),
  .mono           (mono),
  .rx_load        (rx_load),
  .tx_load        (tx_load),
  .rx_left_field  (rx_left_field),
  .lin_left_out   (lin_left_out),
  .lin_right_out  (lin_right_out),
  .tx_left_field  (tx_left_field),
  .tx_right_field (tx_right_field)
);

// File: tb/sample_fmt_conv_tb_top.sv
`timescale 1ns/1ps
module sample_fmt_conv_tb_top;

  localparam logic [1:0] F_LIN = 2'b00;
  localparam logic [1:0] F_OFS = 2'b01;
  localparam logic [1:0] F_MU  = 2'b10;
  localparam logic [1:0] F_AL  = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  fmt_sel;
  logic        mono;
  logic        rx_load;
  logic        tx_load;
  logic [15:0] rx_left_field, rx_right_field;
  logic [15:0] lin_left_out, lin_right_out;
  logic [15:0] lin_left_in, lin_right_in;
  logic [15:0] tx_left_field, tx_right_field;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [63:0] sb_val [$];
  string       sb_req [$];
  logic [63:0] last_exp;
  logic        mon_hit;

  always #2.5 clk = ~clk;

  sample_fmt_conv dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .fmt_sel        (fmt_sel),
    .mono           (mono),
    .rx_load        (rx_load),
    .rx_left_field  (rx_left_field),
    .rx_right_field (rx_right_field),
    .lin_left_out   (lin_left_out),
    .lin_right_out  (lin_right_out),
    .tx_load        (tx_load),
    .lin_left_in    (lin_left_in),
    .lin_right_in   (lin_right_in),
    .tx_left_field  (tx_left_field),
    .tx_right_field (tx_right_field)
  );

  // ---------------- reference model from the requirements ----------------
  function automatic int mu_dec(input int c);
    int u = (~c) & 255;
    int t = (((u & 15) << 3) + 132) << ((u >> 4) & 7);
    return ((u & 128) != 0) ? (132 - t) : (t - 132);
  endfunction

  function automatic int al_dec(input int c);
    int a   = (c ^ 85) & 255;
    int seg = (a >> 4) & 7;
    int t   = (a & 15) << 4;
    if (seg == 0) t = t + 8;
    else begin
      t = t + 264;
      if (seg > 1) t = t << (seg - 1);
    end
    return ((a & 128) != 0) ? t : -t;
  endfunction

  function automatic int mu_enc(input int s);
    int p = s >>> 2;
    int mask = 255;
    int seg = 8;
    if (p < 0) begin p = -p; mask = 127; end
    if (p > 8159) p = 8159;
    p = p + 33;
    for (int i = 7; i >= 0; i--) if (p <= ((64 << i) - 1)) seg = i;
    if (seg >= 8) return (127 ^ mask);
    return (((seg << 4) | ((p >> (seg + 1)) & 15)) ^ mask);
  endfunction

  function automatic int al_enc(input int s);
    int p = s >>> 3;
    int mask = 213;
    int seg = 8;
    int v;
    if (p < 0) begin mask = 85; p = -p - 1; end
    for (int i = 7; i >= 0; i--) if (p <= ((32 << i) - 1)) seg = i;
    v = seg << 4;
    if (seg < 2) v = v | ((p >> 1) & 15);
    else         v = v | ((p >> seg) & 15);
    return (v ^ mask) & 255;
  endfunction

  function automatic logic [15:0] ref_rx(input logic [1:0] f, input logic [15:0] x);
    case (f)
      F_LIN:   return x;
      F_OFS:   return {~x[15], x[14:8], 8'h00};
      F_MU:    return 16'(mu_dec(int'(x[15:8])));
      default: return 16'(al_dec(int'(x[15:8])));
    endcase
  endfunction

  function automatic logic [15:0] ref_tx(input logic [1:0] f, input logic [15:0] x);
    int s = int'($signed(x));
    case (f)
      F_LIN:   return x;
      F_OFS:   return {~x[15], x[14:8], 8'h00};
      F_MU:    return {8'(mu_enc(s)), 8'h00};
      default: return {8'(al_enc(s)), 8'h00};
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- driver: pushes expected items ----------------
  task automatic xfer(input logic [1:0] f, input logic m,
                      input logic [15:0] rl, input logic [15:0] rr,
                      input logic [15:0] tl, input logic [15:0] tr,
                      input string req);
    logic [15:0] el, er, etl, etr;
    el  = ref_rx(f, rl);
    er  = m ? el : ref_rx(f, rr);
    etl = ref_tx(f, tl);
    etr = m ? 16'h0000 : ref_tx(f, tr);
    sb_val.push_back({el, er, etl, etr});
    sb_req.push_back(req);
    last_exp       = {el, er, etl, etr};
    fmt_sel        = f;
    mono           = m;
    rx_left_field  = rl;
    rx_right_field = rr;
    lin_left_in    = tl;
    lin_right_in   = tr;
    rx_load        = 1'b1;
    tx_load        = 1'b1;
    @(negedge clk);
    rx_load = 1'b0;
    tx_load = 1'b0;
    @(negedge clk);
  endtask

  // ---------------- monitor: pops and compares ----------------
  initial begin
    forever begin
      @(posedge clk);
      mon_hit = rx_load;
      #1;
      if (mon_hit && sb_val.size() > 0) begin
        chk(sb_req.pop_front(),
            {lin_left_out, lin_right_out, tx_left_field, tx_right_field},
            sb_val.pop_front());
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0;
    fmt_sel = F_LIN; mono = 1'b0; rx_load = 1'b0; tx_load = 1'b0;
    rx_left_field = '0; rx_right_field = '0; lin_left_in = '0; lin_right_in = '0;
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    chk("R1", {lin_left_out, lin_right_out, tx_left_field, tx_right_field}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: still zero after release, no load yet
    chk("R1", {lin_left_out, lin_right_out, tx_left_field, tx_right_field}, 64'h0);

    // R2: linear passthrough
    xfer(F_LIN, 1'b0, 16'h1234, 16'h8001, 16'hABCD, 16'h0F0F, "R2");
    xfer(F_LIN, 1'b0, 16'h7FFF, 16'h8000, 16'h8000, 16'h7FFF, "R2");
    xfer(F_LIN, 1'b0, 16'h0000, 16'hFFFF, 16'h0001, 16'hFFFE, "R2");

    // R3 R4 R9: offset binary, low byte ignored / zeroed
    xfer(F_OFS, 1'b0, 16'h80FF, 16'h7F5A, 16'h1234, 16'hFF80, "R3_R4_R9");
    xfer(F_OFS, 1'b0, 16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, "R3_R4_R9");

    // R5 R6: mu-law receive sweep over every code, transmit sweep over range
    for (int k = 0; k < 256; k++) begin
      xfer(F_MU, 1'b0, {8'(k), 8'(k * 7)}, {8'(255 - k), 8'h5A},
           16'(-32768 + k * 257), 16'(k * 131 - 16000), "R5_R6");
    end
    // R6: clip and zero corners
    xfer(F_MU, 1'b0, 16'h7F00, 16'hFF00, 16'h7FFF, 16'h8000, "R6");
    xfer(F_MU, 1'b0, 16'h0000, 16'h8000, 16'h0000, 16'hFFFF, "R6");
    xfer(F_MU, 1'b0, 16'h0000, 16'h8000, 16'd32636, 16'(-32640), "R6");

    // R7 R8: A-law receive sweep, transmit sweep
    for (int k = 0; k < 256; k++) begin
      xfer(F_AL, 1'b0, {8'(k), 8'(k * 3)}, {8'(k ^ 8'hAA), 8'hC3},
           16'(32767 - k * 257), 16'(k * 97 - 12000), "R7_R8");
    end
    xfer(F_AL, 1'b0, 16'hD500, 16'h5500, 16'h7FFF, 16'h8000, "R8");
    xfer(F_AL, 1'b0, 16'h5500, 16'hD500, 16'h0000, 16'hFFFF, "R8");

    // R10 R11: mono in each format, right inputs differ from left
    xfer(F_LIN, 1'b1, 16'h2222, 16'h9999, 16'h3333, 16'hAAAA, "R10_R11");
    xfer(F_OFS, 1'b1, 16'hC012, 16'h1234, 16'h4567, 16'h8888, "R10_R11");
    xfer(F_MU,  1'b1, 16'h1E00, 16'hE100, 16'hF000, 16'h1000, "R10_R11");
    xfer(F_AL,  1'b1, 16'hA300, 16'h3A00, 16'h0800, 16'hF800, "R10_R11");

    // R12: inputs change with loads low, outputs must hold
    fmt_sel = F_LIN; mono = 1'b0;
    rx_left_field = 16'h5555; rx_right_field = 16'h6666;
    lin_left_in = 16'h7777; lin_right_in = 16'h1111;
    repeat (3) @(negedge clk);
    chk("R12", {lin_left_out, lin_right_out, tx_left_field, tx_right_field}, last_exp);
    fmt_sel = F_OFS; mono = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12", {lin_left_out, lin_right_out, tx_left_field, tx_right_field}, last_exp);

    repeat (2) @(negedge clk);
    if (sb_val.size() != 0) begin
      chk("scoreboard", 64'(sb_val.size()), 64'h0);
    end
    finish_run();
  end

endmodule